// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital control core of a dual-slope integrating converter. A prescaler divides the oscillator clock into a count clock. A fixed-length conversion frame is built on that count clock, and three mutually exclusive phases run in turn inside it. In auto-zero the analog front end nulls its offsets. Signal integrate has a fixed length. In de-integrate the reference drives the integrator back towards zero while a chain of decimal counters counts. The comparator crossing stops the count. The BCD count and the sign sampled at the end of integration are then moved into a result register, which holds them until the next conversion ends.

The analog integrator, comparator and switches are outside the block. The only analog-side input is the comparator level `cmp_i`: 1 means the integrator output is on the positive side of zero. The outputs are the three phase enables, the reference polarity select and the held reading.

Top module: `dual_slope_seq`

## Requirements
- R1: While `rst_ni` is low, the block is in auto-zero. Its phase enables read az=1, int=0, de=0, and `ref_neg_o`, `rd_bcd_o`, `rd_neg_o` and `rd_ovr_o` are all zero.
- R2: Exactly one of `ph_az_o`, `ph_int_o`, `ph_de_o` is high at all times. The phases always advance in the order auto-zero, integrate, de-integrate, auto-zero.
- R3: One count spans exactly OSC_DIV clock periods, and every phase duration is a whole number of counts.
- R4: Signal integrate lasts exactly INT_COUNTS counts, whatever the input.
- R5: The time from one integrate start to the next is always CYCLE_COUNTS counts.
- R6: At the last count of integrate, `ref_neg_o` takes the value of `cmp_i`. It then holds that value until the next integrate ends.
- R7: De-integrate ends on the first count at which `cmp_i` differs from the sampled polarity. The reading is the number of de-integrate counts completed before that count, so a crossing seen on the first count reads 0. The reading is given as BCD with units in bits [3:0], tens in [7:4] and so on.
- R8: If no crossing is seen by de-integrate count DE_MAX, de-integrate ends at that count. The result then has `rd_ovr_o`=1 and all BCD digits zero.
- R9: The result register loads only at the end of de-integrate and holds its value at all other times. `rd_neg_o` is 1 when the sampled `cmp_i` was 0.
- R10: Auto-zero takes the remainder of the frame: CYCLE_COUNTS − INT_COUNTS − D counts, where D is the number of counts spent in de-integrate.
- R11: The first auto-zero after reset lasts CYCLE_COUNTS − INT_COUNTS − DE_MAX counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Comparator level, 1 = integrator positive |
| ph_az_o | output | 1 | Auto-zero phase enable |
| ph_int_o | output | 1 | Signal integrate phase enable |
| ph_de_o | output | 1 | De-integrate phase enable |
| ref_neg_o | output | 1 | Apply reference with negative polarity |
| rd_bcd_o | output | 4*DIGITS | Held BCD reading |
| rd_neg_o | output | 1 | Held sign, 1 = negative input |
| rd_ovr_o | output | 1 | Held over-range flag |

## Verification
The bench samples every output at the falling clock edge. It measures each phase in whole clock periods from the edge where the enable changed. Integrate is due INT_COUNTS×OSC_DIV clocks after it starts. De-integrate ends (N+1)×OSC_DIV clocks after it starts when the comparator flips N×OSC_DIV clocks into it, or DE_MAX×OSC_DIV clocks after it starts on over-range. The result register changes at the same edge that raises auto-zero, so the bench reads it at the first falling edge where auto-zero is seen. It checks that the register still holds that value at the next integrate start. The sweep covers every crossing point from 0 to DE_MAX+2 counts for both polarities, on a small frame.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_e;
endpackage

// File: rtl/dss_prescale.sv
module dss_prescale #(
  parameter int OSC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(OSC_DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dss_decade_chain.sv
module dss_decade_chain #(
  parameter int DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   bcd_o
);
  logic [DIGITS-1:0] cy;

  assign cy[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    logic [3:0] dig_q;

    if (g > 0) begin : g_cy
      assign cy[g] = cy[g-1] && (g_dec[g-1].dig_q == 4'd9);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dig_q <= '0;
      else if (clr_i)   dig_q <= '0;
      else if (cy[g])   dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end

    assign bcd_o[4*g +: 4] = dig_q;
  end
endmodule

// File: rtl/dss_phase_ctrl.sv
module dss_phase_ctrl
  import dss_pkg::*;
#(
  parameter int INT_COUNTS   = 1000,
  parameter int DE_MAX       = 2000,
  parameter int CYCLE_COUNTS = 4000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   cmp_i,
  output phase_e phase_o,
  output logic   ref_neg_o,
  output logic   clr_o,
  output logic   inc_o,
  output logic   done_o,
  output logic   ovr_o
);
  localparam int TOT_W = $clog2(CYCLE_COUNTS);
  localparam logic [TOT_W-1:0] TOT_LAST = TOT_W'(CYCLE_COUNTS - 1);
  localparam logic [TOT_W-1:0] INT_LAST = TOT_W'(INT_COUNTS - 1);
  localparam logic [TOT_W-1:0] DE_LAST  = TOT_W'(INT_COUNTS + DE_MAX - 1);
  localparam logic [TOT_W-1:0] TOT_RST  = TOT_W'(INT_COUNTS + DE_MAX);

  phase_e           phase_q;
  logic [TOT_W-1:0] tot_q;
  logic             pol_q;
  logic             crossed, last_de, in_de;

  always_comb begin
    in_de   = tick_i && (phase_q == PH_DE);
    crossed = (cmp_i != pol_q);
    last_de = (tot_q == DE_LAST);
    inc_o   = in_de && !crossed && !last_de;
    done_o  = in_de && (crossed || last_de);
    ovr_o   = !crossed && last_de;
    clr_o   = tick_i && (phase_q == PH_AZ) && (tot_q == TOT_LAST);
  end

  // frame position counts every tick; phases are decoded against it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      tot_q   <= TOT_RST;
      pol_q   <= 1'b0;
    end else if (tick_i) begin
      tot_q <= (tot_q == TOT_LAST) ? '0 : tot_q + 1'b1;
      unique case (phase_q)
        PH_AZ:  if (tot_q == TOT_LAST) phase_q <= PH_INT;
        PH_INT: if (tot_q == INT_LAST) begin
                  phase_q <= PH_DE;
                  pol_q   <= cmp_i;
                end
        PH_DE:  if (done_o) phase_q <= PH_AZ;
        default: phase_q <= PH_AZ;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign ref_neg_o = pol_q;
endmodule

// File: rtl/dss_result_latch.sv
module dss_result_latch #(
  parameter int BCD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BCD_W-1:0] bcd_i,
  input  logic             neg_i,
  input  logic             ovr_i,
  output logic [BCD_W-1:0] bcd_o,
  output logic             neg_o,
  output logic             ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcd_o <= '0;
      neg_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (load_i) begin
      bcd_o <= ovr_i ? '0 : bcd_i;
      neg_o <= neg_i;
      ovr_o <= ovr_i;
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int OSC_DIV      = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DE_MAX       = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DIGITS       = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmp_i,
  output logic                ph_az_o,
  output logic                ph_int_o,
  output logic                ph_de_o,
  output logic                ref_neg_o,
  output logic [4*DIGITS-1:0] rd_bcd_o,
  output logic                rd_neg_o,
  output logic                rd_ovr_o
);
  localparam int BCD_W = 4 * DIGITS;

  logic             tick, clr, inc, done, ovr;
  phase_e           phase;
  logic [BCD_W-1:0] bcd;

  dss_prescale #(.OSC_DIV(OSC_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  dss_phase_ctrl #(
    .INT_COUNTS   (INT_COUNTS),
    .DE_MAX       (DE_MAX),
    .CYCLE_COUNTS (CYCLE_COUNTS)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cmp_i     (cmp_i),
    .phase_o   (phase),
    .ref_neg_o (ref_neg_o),
    .clr_o     (clr),
    .inc_o     (inc),
    .done_o    (done),
    .ovr_o     (ovr)
  );

  dss_decade_chain #(.DIGITS(DIGITS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .bcd_o  (bcd)
  );

  dss_result_latch #(.BCD_W(BCD_W)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done),
    .bcd_i  (bcd),
    .neg_i  (!ref_neg_o),
    .ovr_i  (ovr),
    .bcd_o  (rd_bcd_o),
    .neg_o  (rd_neg_o),
    .ovr_o  (rd_ovr_o)
  );

  assign ph_az_o  = (phase == PH_AZ);
  assign ph_int_o = (phase == PH_INT);
  assign ph_de_o  = (phase == PH_DE);
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int OSC_DIV    = 4,
  parameter int INT_COUNTS = 1000,
  parameter int BCD_W      = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_i,
  input logic             ph_az_o,
  input logic             ph_int_o,
  input logic             ph_de_o,
  input logic             ref_neg_o,
  input logic [BCD_W-1:0] rd_bcd_o,
  input logic             rd_neg_o,
  input logic             rd_ovr_o
);
  int unsigned int_clks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       int_clks <= 0;
    else if (ph_int_o) int_clks <= int_clks + 1;
    else               int_clks <= 0;
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({ph_az_o, ph_int_o, ph_de_o}));

  p_int_to_de_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_int_o) |-> ph_de_o);

  p_de_to_az_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_de_o) |-> ph_az_o);

  p_az_to_int_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_az_o) |-> ph_int_o);

  p_int_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_int_o) |-> (int_clks == OSC_DIV * INT_COUNTS));

  p_pol_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_de_o) |-> (ref_neg_o == $past(cmp_i)));

  p_pol_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_de_o && $past(ph_de_o)) |-> $stable(ref_neg_o));

  p_ovr_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ovr_o |-> (rd_bcd_o == '0));

  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(ph_de_o) |-> $stable({rd_bcd_o, rd_neg_o, rd_ovr_o}));

  p_sign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_de_o) |-> (rd_neg_o == !ref_neg_o));
endmodule

bind dual_slope_seq dual_slope_seq_chk #(
  .OSC_DIV    (OSC_DIV),
  .INT_COUNTS (INT_COUNTS),
  .BCD_W      (4 * DIGITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmp_i     (cmp_i),
  .ph_az_o   (ph_az_o),
  .ph_int_o  (ph_int_o),
  .ph_de_o   (ph_de_o),
  .ref_neg_o (ref_neg_o),
  .rd_bcd_o  (rd_bcd_o),
  .rd_neg_o  (rd_neg_o),
  .rd_ovr_o  (rd_ovr_o)
);

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
  localparam int DIV   = 4;
  localparam int INTC  = 10;
  localparam int DEMAX = 20;
  localparam int CYC   = 40;
  localparam int DIG   = 2;
  localparam int BW    = 4 * DIG;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmp_i = 1'b0;
  logic          ph_az_o, ph_int_o, ph_de_o, ref_neg_o, rd_neg_o, rd_ovr_o;
  logic [BW-1:0] rd_bcd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dual_slope_seq #(
    .OSC_DIV(DIV), .INT_COUNTS(INTC), .DE_MAX(DEMAX),
    .CYCLE_COUNTS(CYC), .DIGITS(DIG)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i),
    .ph_az_o(ph_az_o), .ph_int_o(ph_int_o), .ph_de_o(ph_de_o),
    .ref_neg_o(ref_neg_o), .rd_bcd_o(rd_bcd_o),
    .rd_neg_o(rd_neg_o), .rd_ovr_o(rd_ovr_o)
  );

  function automatic logic [BW-1:0] to_bcd(int v);
    logic [BW-1:0] r = '0;
    for (int i = 0; i < DIG; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: one phase enable at every sampled edge
  always @(negedge clk_i) begin
    if (rst_ni && !done)
      chk("R2 onehot", int'(ph_az_o) + int'(ph_int_o) + int'(ph_de_o), 1);
  end

  // one conversion: entered at the falling edge where integrate is first seen
  task automatic run(bit s, int n);
    int ti = 0, td = 0, ta = 0, m = 0, dlen;
    logic [BW-1:0] exp_bcd;
    bit ovr;
    ovr = (n >= DEMAX);
    dlen = ovr ? DEMAX : n + 1;
    exp_bcd = ovr ? '0 : to_bcd(n);
    cmp_i = s;
    while (!ph_de_o) begin @(negedge clk_i); ti++; end
    chk("R4/R3 integrate clocks", ti, INTC * DIV);
    chk("R6 ref polarity", int'(ref_neg_o), int'(s));
    if (n == 0) cmp_i = ~s;
    while (!ph_az_o) begin
      @(negedge clk_i); td++; m++;
      if (m == n * DIV) cmp_i = ~s;
    end
    chk(ovr ? "R8 deint clocks" : "R7 deint clocks", td, dlen * DIV);
    chk(ovr ? "R8 reading" : "R7 reading", int'(rd_bcd_o), int'(exp_bcd));
    chk("R8 overrange flag", int'(rd_ovr_o), int'(ovr));
    chk("R9 sign", int'(rd_neg_o), int'(!s));
    while (!ph_int_o) begin
      @(negedge clk_i); ta++; m++;
      if (m == n * DIV) cmp_i = ~s;
    end
    chk("R10 autozero clocks", ta, (CYC - INTC - dlen) * DIV);
    chk("R5 frame clocks", ti + td + ta, CYC * DIV);
    chk("R9 hold reading", int'(rd_bcd_o), int'(exp_bcd));
    chk("R9 hold flags", int'({rd_neg_o, rd_ovr_o}), int'({!s, ovr}));
    chk("R6 ref held", int'(ref_neg_o), int'(s));
  endtask

  initial begin
    int n0 = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 az", int'(ph_az_o), 1);
    chk("R1 int/de", int'({ph_int_o, ph_de_o}), 0);
    chk("R1 ref", int'(ref_neg_o), 0);
    chk("R1 result", int'({rd_bcd_o, rd_neg_o, rd_ovr_o}), 0);
    rst_ni = 1'b1;
    while (!ph_int_o) begin @(negedge clk_i); n0++; end
    chk("R11 first autozero clocks", n0, (CYC - INTC - DEMAX) * DIV);
    for (int s = 1; s >= 0; s--)
      for (int n = 0; n <= DEMAX + 2; n++)
        run(1'(s), n);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule